// File: doc/BRIEF.md
# Serial EEPROM Write-Cycle Sequencer

This block times the internal programming cycle of a serial EEPROM slave. The bus engine reports each valid STOP it detects, and whether the transfer it closes was a write that delivered at least one data byte. When both are true, the sequencer issues a one-clock commit strobe. That strobe tells the page buffer to move everything it gathered into the array in a single operation. The sequencer then holds `busy` for a fixed number of system clocks, which stands for the programming time (10 ms maximum in silicon).

While `busy` is high, the bus engine must keep SDA released and ignore traffic. The sequencer raises `addr_nack` so that the device's own slave address is not acknowledged. A host that keeps sending START plus a write address therefore sees no ACK until programming ends, and gets an ACK on the first attempt after it ends. After reset, the same `addr_nack` refuses all access for a programmable power-up delay (1 ms in silicon), and `ready` marks its end.

There are four states:
- POWERUP is entered on reset and moves to IDLE when the power-up delay expires.
- IDLE moves to COMMIT on a STOP that closes a write with data, and ignores everything else.
- COMMIT lasts one clock. It moves to BUSY, or straight back to IDLE if the write time is a single clock.
- BUSY returns to IDLE when the write-time counter expires.

Top module: `eeprom_wcycle_ctrl`

## Requirements
- R1: While reset is held, `ready`=0, `busy`=0, `commit`=0 and `addr_nack`=1.
- R2: After reset is released, `ready` stays 0 and `addr_nack` stays 1 for exactly PWRUP_CYCLES clocks. Then `ready` becomes 1 and stays 1 until the next reset.
- R3: A STOP that closes a write with data, arriving while `ready`=0, starts no write cycle.
- R4: With `ready`=1 and `busy`=0, a clock on which `stop_seen`=1 and `wr_data_seen`=1 makes `commit` and `busy` both 1 on the next clock.
- R5: Once started, `busy` stays 1 for exactly WRITE_CYCLES consecutive clocks, counting the commit clock.
- R6: `addr_nack` is 1 on every clock on which `busy` is 1.
- R7: A STOP with `wr_data_seen`=0 (a header-only or dummy write), or `wr_data_seen`=1 without a STOP, starts no write cycle.
- R8: `stop_seen` and `wr_data_seen` are ignored while `busy`=1. The cycle still ends on schedule and no second commit occurs inside it.
- R9: On the first clock after `busy` falls, `addr_nack` is 0, and a new qualifying STOP on that clock starts a new cycle.
- R10: `commit` is 1 only on the first clock of each busy period, exactly once per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; models power becoming stable |
| stop_seen | input | 1 | One-clock pulse from the bus engine on a valid STOP |
| wr_data_seen | input | 1 | High when the transfer being closed is a write that received at least one data byte |
| ready | output | 1 | Power-up delay has elapsed |
| busy | output | 1 | Programming cycle in progress; the bus engine must ignore the bus and release SDA |
| commit | output | 1 | One-clock strobe telling the page buffer to write its contents into the array |
| addr_nack | output | 1 | Bus engine must not acknowledge the slave address |

## Verification
The bench measures the length of each busy period clock by clock. An off-by-one in the write-time counter, or a commit clock left out of the count, shows up directly as a wrong length.

It fires a qualifying STOP during the power-up window and another in the middle of a busy period. A design that listened in either window would start a cycle early, or would stretch the cycle or commit twice. Dummy writes and data flags without a STOP are mixed into a stimulus table, so a sequencer that keyed on only one of its two inputs would commit when it should not. Finally, a new write is issued on the very first idle clock. This catches a design that keeps `addr_nack` high, or blocks a restart, one clock too long.

// File: rtl/eewc_pkg.sv
package eewc_pkg;
    typedef enum logic [1:0] {
        WC_POWERUP,
        WC_IDLE,
        WC_COMMIT,
        WC_BUSY
    } wc_state_e;
endpackage

// File: rtl/eewc_delay.sv
// Elapsed-clock detector: done rises on the LIMIT-th consecutive clock with run high.
module eewc_delay #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    generate
        if (LIMIT <= 1) begin : g_single
            assign done = run;
        end else begin : g_count
            localparam int CW = $clog2(LIMIT);
            localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!run) begin
                    cnt_q <= '0;
                end else if (cnt_q != LAST) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign done = run && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/eewc_fsm.sv
module eewc_fsm
    import eewc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_seen,
    input  logic wr_data_seen,
    input  logic pwr_done,
    input  logic wr_done,
    output logic pwr_run,
    output logic wr_run,
    output logic ready,
    output logic busy,
    output logic commit,
    output logic addr_nack
);
    wc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WC_POWERUP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WC_POWERUP: if (pwr_done) state_d = WC_IDLE;
            WC_IDLE:    if (stop_seen && wr_data_seen) state_d = WC_COMMIT;
            WC_COMMIT:  state_d = wr_done ? WC_IDLE : WC_BUSY;
            WC_BUSY:    if (wr_done) state_d = WC_IDLE;
            default:    state_d = WC_POWERUP;
        endcase
    end

    always_comb begin
        pwr_run   = 1'b0;
        wr_run    = 1'b0;
        ready     = 1'b1;
        busy      = 1'b0;
        commit    = 1'b0;
        addr_nack = 1'b0;
        unique case (state_q)
            WC_POWERUP: begin
                pwr_run   = 1'b1;
                ready     = 1'b0;
                addr_nack = 1'b1;
            end
            WC_IDLE: begin
            end
            WC_COMMIT: begin
                wr_run    = 1'b1;
                busy      = 1'b1;
                commit    = 1'b1;
                addr_nack = 1'b1;
            end
            WC_BUSY: begin
                wr_run    = 1'b1;
                busy      = 1'b1;
                addr_nack = 1'b1;
            end
            default: begin
                ready     = 1'b0;
                addr_nack = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/eeprom_wcycle_ctrl.sv
module eeprom_wcycle_ctrl #(
    parameter int WRITE_CYCLES = 500000,
    parameter int PWRUP_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_seen,
    input  logic wr_data_seen,
    output logic ready,
    output logic busy,
    output logic commit,
    output logic addr_nack
);
    logic pwr_run, pwr_done;
    logic wr_run, wr_done;

    eewc_delay #(.LIMIT(PWRUP_CYCLES)) i_pwr_delay (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (pwr_run),
        .done (pwr_done)
    );

    eewc_delay #(.LIMIT(WRITE_CYCLES)) i_wr_delay (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (wr_run),
        .done (wr_done)
    );

    eewc_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_seen   (stop_seen),
        .wr_data_seen(wr_data_seen),
        .pwr_done    (pwr_done),
        .wr_done     (wr_done),
        .pwr_run     (pwr_run),
        .wr_run      (wr_run),
        .ready       (ready),
        .busy        (busy),
        .commit      (commit),
        .addr_nack   (addr_nack)
    );
endmodule

// File: rtl/eewc_checker.sv
module eewc_checker #(
    parameter int WRITE_CYCLES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic stop_seen,
    input logic wr_data_seen,
    input logic ready,
    input logic busy,
    input logic commit,
    input logic addr_nack
);
    int run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= 0;
        end else if (busy) begin
            run_len <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ready |=> ready); // R2
    AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !ready |-> (!busy && addr_nack)); // R3
    AST_WRITE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !busy && stop_seen && wr_data_seen) |=> (commit && busy)); // R4
    AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (run_len < WRITE_CYCLES)); // R5
    AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (run_len == WRITE_CYCLES)); // R5
    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n) busy |-> addr_nack); // R6
    AST_DUMMY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !busy && !(stop_seen && wr_data_seen)) |=> !busy); // R7
    AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> !addr_nack); // R9
    AST_COMMIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n) commit |-> (busy && run_len == 0)); // R10
    AST_RISE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> commit); // R10
endmodule

bind eeprom_wcycle_ctrl eewc_checker #(.WRITE_CYCLES(WRITE_CYCLES)) i_eewc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_seen   (stop_seen),
    .wr_data_seen(wr_data_seen),
    .ready       (ready),
    .busy        (busy),
    .commit      (commit),
    .addr_nack   (addr_nack)
);

// File: tb/test_eeprom_wcycle_ctrl.sv
module test_eeprom_wcycle_ctrl;
    localparam int PWR = 20;
    localparam int WR  = 12;

    // Vector bits: {stop_seen, wr_data_seen, cycle expected}
    localparam logic [2:0] VEC [6] = '{3'b111, 3'b100, 3'b010, 3'b111, 3'b000, 3'b111};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_seen = 1'b0;
    logic wr_data_seen = 1'b0;
    logic ready, busy, commit, addr_nack;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    eeprom_wcycle_ctrl #(.WRITE_CYCLES(WR), .PWRUP_CYCLES(PWR)) i_eeprom_wcycle_ctrl (
        .clk(clk), .rst_n(rst_n), .stop_seen(stop_seen), .wr_data_seen(wr_data_seen),
        .ready(ready), .busy(busy), .commit(commit), .addr_nack(addr_nack)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drives one pulse, then follows the resulting busy period at negedges.
    task automatic pulse(input bit s, input bit d, input int inject,
                         output int c, output int len, output int ncom, output int nbad);
        stop_seen = s;
        wr_data_seen = d;
        @(negedge clk);
        stop_seen = 1'b0;
        wr_data_seen = 1'b0;
        c = int'(commit);
        len = 0;
        ncom = 0;
        nbad = 0;
        while (busy === 1'b1 && len < 4 * WR) begin
            len++;
            if (commit) ncom++;
            if (!addr_nack) nbad++;
            if (len == inject) begin
                stop_seen = 1'b1;
                wr_data_seen = 1'b1;
            end
            @(negedge clk);
            stop_seen = 1'b0;
            wr_data_seen = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c, len, ncom, nbad, n, early;
        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", int'(ready), 0);
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "commit in reset", int'(commit), 0);
        chk("R1", "addr_nack in reset", int'(addr_nack), 1);

        // Power-up window, with a qualifying STOP fired into it (R3)
        rst_n = 1'b1;
        n = 0;
        early = 0;
        while (ready !== 1'b1 && n < 1000) begin
            if (busy || !addr_nack) early++;
            n++;
            if (n == 6) begin
                stop_seen = 1'b1;
                wr_data_seen = 1'b1;
            end
            @(negedge clk);
            stop_seen = 1'b0;
            wr_data_seen = 1'b0;
        end
        chk("R2", "power-up clocks", n, PWR);
        chk("R2", "addr_nack after power-up", int'(addr_nack), 0);
        chk("R3", "busy/nack faults during power-up", early, 0);
        chk("R3", "busy after power-up", int'(busy), 0);

        // Table of stimulus vectors (R4 R5 R6 R7 R9)
        foreach (VEC[i]) begin
            pulse(VEC[i][2], VEC[i][1], -1, c, len, ncom, nbad);
            if (VEC[i][0]) begin
                chk("R4", $sformatf("commit vec%0d", i), c, 1);
                chk("R5", $sformatf("busy length vec%0d", i), len, WR);
                chk("R6", $sformatf("addr_nack drops vec%0d", i), nbad, 0);
                chk("R9", $sformatf("addr_nack idle vec%0d", i), int'(addr_nack), 0);
            end else begin
                chk("R7", $sformatf("no commit vec%0d", i), c, 0);
                chk("R7", $sformatf("no busy vec%0d", i), len, 0);
            end
        end

        // Traffic inside a busy period is ignored (R8, R10)
        pulse(1'b1, 1'b1, 3, c, len, ncom, nbad);
        chk("R8", "busy length with mid-cycle STOP", len, WR);
        chk("R10", "commits per busy period", ncom, 1);
        chk("R8", "no restart after mid-cycle STOP", int'(busy), 0);

        // Restart on the first idle clock (R9)
        chk("R9", "addr_nack on first idle clock", int'(addr_nack), 0);
        pulse(1'b1, 1'b1, -1, c, len, ncom, nbad);
        chk("R9", "back-to-back commit", c, 1);
        chk("R9", "back-to-back length", len, WR);

        // Reset brings back the power-up state (R1)
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "ready after re-reset", int'(ready), 0);
        chk("R1", "addr_nack after re-reset", int'(addr_nack), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule